// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

The block starts running as soon as reset is released. It fetches a register initialisation image from an external serial EEPROM and writes every entry of that image into the chip's internal register file. After all entries are written, it reads the whole image a second time and compares each entry with the value the register file now returns. The EEPROM can be an I2C or an SPI part. A static mode pin selects which one, and the same sequencer serves both. The bit-level serial engine sits outside this block. The loader sends it one byte-level command at a time (start, write byte, read byte, stop) and waits for one response to each command.

While the boot runs, host writes into the register file are held off. When the boot ends, the block raises a done flag, and the host write port is then connected straight through to the register file. An error flag set at the same moment reports a bad header, an oversized image, an unacknowledged I2C byte or a verify mismatch. Between two EEPROM transfers the block always waits for a programmable number of cycles.

Command channel: `cmd_valid` rises with the op, data and last fields already valid. These fields stay unchanged until `cmd_ready` is sampled high. Response channel: `rsp_ready` is high only while a response is owed. The serial engine may stall either channel for any number of cycles. The block never has more than one command in flight.

Top module: `eeprom_boot`

## Requirements
- R1: While reset is held and after it is released, `boot_busy` is 1 and `boot_done` and `boot_error` are 0. The boot then starts by itself. Once `boot_done` rises it stays high, `boot_busy` falls, `boot_error` holds its value, and no further serial command is issued.
- R2: The image is big-endian and starts with a 4-byte header at EEPROM address 0. Bytes 0-1 hold the magic value, which is 16'hB007 by default. Bytes 2-3 hold the entry count. Entries of 3 bytes follow from address 4: register address high byte, register address low byte, data. Each entry is written once, in image order, as a one-cycle `reg_we` pulse.
- R3: If the magic value does not match, the boot ends with done and error set. No register is written.
- R4: An entry count of 0 ends the boot after the header transfer with error clear and no writes. A count larger than the number of entries that fit in a 64 KiB device (21844) ends the boot with error set and no writes.
- R5: From the response to one transfer's stop command to the next transfer's start command, at least `wait_cycles` clock cycles pass.
- R6: Op codes are start=0, write=1, read=2, stop=3. In I2C mode a transfer is: start, write {device id,0}, write address high, write address low, start, write {device id,1}, the reads, stop. `cmd_last` is 1 only on the final read.
- R7: In SPI mode a transfer is: start, write 8'h03, write address high, write address low, the reads, stop. `rsp_ack` is ignored in SPI mode.
- R8: In I2C mode, a write whose response has `rsp_ack`=0 makes the block issue a stop and end the boot with error set. No register write follows.
- R9: After loading, each entry is read back from the EEPROM and compared with `reg_rdata` for that entry's address. A mismatch ends the boot with error set. If all entries match, the boot ends with error clear.
- R10: Host writes (`host_we`) never reach `reg_we` while `boot_busy` is 1. After done they pass through unchanged.
- R11: Command fields hold steady while `cmd_valid` is high and not yet accepted. `cmd_valid` is never high while a response is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spi_mode | input | 1 | 1 selects SPI framing, 0 selects I2C (static) |
| wait_cycles | input | WAIT_W | Minimum idle cycles between transfers |
| cmd_valid | output | 1 | Serial command offered |
| cmd_ready | input | 1 | Serial engine accepts command |
| cmd_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | output | 8 | Byte to write |
| cmd_last | output | 1 | Final read of a transfer |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Block takes response |
| rsp_data | input | 8 | Byte returned by a read |
| rsp_ack | input | 1 | I2C acknowledge for a write |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 8 | Host write data |
| reg_we | output | 1 | Register file write strobe |
| reg_addr | output | 16 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_rdata | input | 8 | Register file read data for reg_addr |
| boot_done | output | 1 | Boot finished |
| boot_busy | output | 1 | Boot in progress |
| boot_error | output | 1 | Boot failed |

## Verification
The bench builds the block with its default parameters: magic 16'hB007, device id 7'h50, SPI read op 8'h03 and a 16-bit wait field. Images of up to six entries are placed in the lowest 256 EEPROM bytes. Wait values of 0, 3 and 5, together with serial-engine stalls on both channels, exercise the gap timer, the back-pressure rules and both framings within a few thousand cycles. Setting the count to 16'h6000 reaches the oversize limit without the bench having to store a large image.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int EE_AW     = 16;
  localparam int REG_AW    = 16;
  localparam int HDR_BYTES = 4;
  localparam int ENT_BYTES = 3;
  localparam int BUF_W     = 8 * HDR_BYTES;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);
  localparam logic [15:0] MAX_ENT = 16'(((1 << EE_AW) - HDR_BYTES) / ENT_BYTES);

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } ser_op_e;

  typedef enum logic [3:0] {
    PH_START, PH_DEVW, PH_OPC, PH_AHI, PH_ALO,
    PH_RSTART, PH_DEVR, PH_READ, PH_STOP
  } xfer_ph_e;

  typedef enum logic [3:0] {
    S_HDR_GO, S_HDR_RUN, S_LD_GO, S_LD_RUN, S_WR,
    S_VF_GO, S_VF_RUN, S_CMP, S_GAP, S_DONE
  } boot_st_e;
endpackage

// File: rtl/boot_wait.sv
module boot_wait #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] len,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= len;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;
endmodule

// File: rtl/boot_xfer.sv
module boot_xfer
  import boot_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter logic [7:0] SPI_RD_OP = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_mode,
  input  logic             go,
  input  logic [EE_AW-1:0] start_addr,
  input  logic [CNT_W-1:0] nbytes,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_last,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_ack,
  output logic             done,
  output logic             nack,
  output logic [BUF_W-1:0] rx_buf
);
  xfer_ph_e         phase, phase_n;
  logic             active, wait_rsp, nack_q, is_write;
  logic [EE_AW-1:0] addr_q;
  logic [CNT_W-1:0] remain;

  // next phase of the framing, chosen by mode
  always_comb begin
    phase_n = phase;
    unique case (phase)
      PH_START:  phase_n = spi_mode ? PH_OPC : PH_DEVW;
      PH_DEVW:   phase_n = PH_AHI;
      PH_OPC:    phase_n = PH_AHI;
      PH_AHI:    phase_n = PH_ALO;
      PH_ALO:    phase_n = spi_mode ? PH_READ : PH_RSTART;
      PH_RSTART: phase_n = PH_DEVR;
      PH_DEVR:   phase_n = PH_READ;
      PH_READ:   phase_n = (remain == CNT_W'(1)) ? PH_STOP : PH_READ;
      PH_STOP:   phase_n = PH_STOP;
      default:   phase_n = PH_STOP;
    endcase
  end

  always_comb begin
    cmd_op   = OP_START;
    cmd_data = 8'h00;
    cmd_last = 1'b0;
    is_write = 1'b1;
    unique case (phase)
      PH_START, PH_RSTART: begin cmd_op = OP_START; is_write = 1'b0; end
      PH_DEVW: begin cmd_op = OP_WRITE; cmd_data = {DEV_ID, 1'b0}; end
      PH_DEVR: begin cmd_op = OP_WRITE; cmd_data = {DEV_ID, 1'b1}; end
      PH_OPC:  begin cmd_op = OP_WRITE; cmd_data = SPI_RD_OP; end
      PH_AHI:  begin cmd_op = OP_WRITE; cmd_data = addr_q[EE_AW-1:8]; end
      PH_ALO:  begin cmd_op = OP_WRITE; cmd_data = addr_q[7:0]; end
      PH_READ: begin
        cmd_op   = OP_READ;
        cmd_last = (remain == CNT_W'(1));
        is_write = 1'b0;
      end
      PH_STOP: begin cmd_op = OP_STOP; is_write = 1'b0; end
      default: begin cmd_op = OP_STOP; is_write = 1'b0; end
    endcase
  end

  assign cmd_valid = active && !wait_rsp;
  assign rsp_ready = active && wait_rsp;
  assign done      = rsp_ready && rsp_valid && (phase == PH_STOP);
  assign nack      = nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wait_rsp <= 1'b0;
      nack_q   <= 1'b0;
      phase    <= PH_START;
      addr_q   <= '0;
      remain   <= '0;
      rx_buf   <= '0;
    end else if (go && !active) begin
      active   <= 1'b1;
      wait_rsp <= 1'b0;
      nack_q   <= 1'b0;
      phase    <= PH_START;
      addr_q   <= start_addr;
      remain   <= nbytes;
    end else if (active) begin
      if (!wait_rsp) begin
        if (cmd_ready) wait_rsp <= 1'b1;
      end else if (rsp_valid) begin
        wait_rsp <= 1'b0;
        if (phase == PH_READ) begin
          rx_buf <= {rx_buf[BUF_W-9:0], rsp_data};
          remain <= remain - 1'b1;
        end
        if (phase == PH_STOP) begin
          active <= 1'b0;
        end else if (is_write && !spi_mode && !rsp_ack) begin
          nack_q <= 1'b1;
          phase  <= PH_STOP;
        end else begin
          phase  <= phase_n;
        end
      end
    end
  end
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter logic [15:0] BOOT_MAGIC = 16'hB007
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              xfer_go,
  output logic [EE_AW-1:0]  xfer_addr,
  output logic [CNT_W-1:0]  xfer_n,
  input  logic              xfer_done,
  input  logic              xfer_nack,
  input  logic [BUF_W-1:0]  xfer_rx,
  output logic              tmr_load,
  input  logic              tmr_expired,
  output logic              boot_we,
  output logic [REG_AW-1:0] boot_addr,
  output logic [7:0]        boot_wdata,
  input  logic [7:0]        reg_rdata,
  output logic              done,
  output logic              error
);
  boot_st_e         st, st_n;
  logic [EE_AW-1:0] ee_addr, ee_n;
  logic [15:0]      ent, ent_n, count, cnt_n;
  logic             verify, ver_n, err_q, err_n, last_ent;
  logic [15:0]      hdr_magic, hdr_count;
  logic [7:0]       ent_data;

  assign hdr_magic = xfer_rx[31:16];
  assign hdr_count = xfer_rx[15:0];
  assign boot_addr = xfer_rx[23:8];
  assign ent_data  = xfer_rx[7:0];
  assign last_ent  = (ent == count - 16'd1);

  always_comb begin
    st_n  = st;
    ee_n  = ee_addr;
    ent_n = ent;
    cnt_n = count;
    ver_n = verify;
    err_n = err_q;
    unique case (st)
      S_HDR_GO: st_n = S_HDR_RUN;
      S_HDR_RUN: if (xfer_done) begin
        if (xfer_nack || hdr_magic != BOOT_MAGIC || hdr_count > MAX_ENT) begin
          err_n = 1'b1;
          st_n  = S_DONE;
        end else if (hdr_count == 16'd0) begin
          st_n = S_DONE;
        end else begin
          cnt_n = hdr_count;
          ee_n  = EE_AW'(HDR_BYTES);
          ent_n = 16'd0;
          st_n  = S_GAP;
        end
      end
      S_LD_GO: st_n = S_LD_RUN;
      S_LD_RUN: if (xfer_done) begin
        if (xfer_nack) begin err_n = 1'b1; st_n = S_DONE; end
        else st_n = S_WR;
      end
      S_WR: begin
        st_n = S_GAP;
        if (last_ent) begin
          ver_n = 1'b1;
          ent_n = 16'd0;
          ee_n  = EE_AW'(HDR_BYTES);
        end else begin
          ent_n = ent + 16'd1;
          ee_n  = ee_addr + EE_AW'(ENT_BYTES);
        end
      end
      S_GAP: if (tmr_expired) st_n = verify ? S_VF_GO : S_LD_GO;
      S_VF_GO: st_n = S_VF_RUN;
      S_VF_RUN: if (xfer_done) begin
        if (xfer_nack) begin err_n = 1'b1; st_n = S_DONE; end
        else st_n = S_CMP;
      end
      S_CMP: begin
        if (reg_rdata != ent_data) begin
          err_n = 1'b1;
          st_n  = S_DONE;
        end else if (last_ent) begin
          st_n = S_DONE;
        end else begin
          ent_n = ent + 16'd1;
          ee_n  = ee_addr + EE_AW'(ENT_BYTES);
          st_n  = S_GAP;
        end
      end
      S_DONE:  st_n = S_DONE;
      default: st_n = S_DONE;
    endcase
  end

  assign tmr_load   = (st_n == S_GAP) && (st != S_GAP);
  assign xfer_go    = (st == S_HDR_GO) || (st == S_LD_GO) || (st == S_VF_GO);
  assign xfer_addr  = ee_addr;
  assign xfer_n     = (st == S_HDR_GO) ? CNT_W'(HDR_BYTES) : CNT_W'(ENT_BYTES);
  assign boot_we    = (st == S_WR);
  assign boot_wdata = ent_data;
  assign done       = (st == S_DONE);
  assign error      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HDR_GO;
      ee_addr <= '0;
      ent     <= '0;
      count   <= '0;
      verify  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st      <= st_n;
      ee_addr <= ee_n;
      ent     <= ent_n;
      count   <= cnt_n;
      verify  <= ver_n;
      err_q   <= err_n;
    end
  end
endmodule

// File: rtl/eeprom_boot.sv
module eeprom_boot
  import boot_pkg::*;
#(
  parameter logic [15:0] BOOT_MAGIC = 16'hB007,
  parameter logic [6:0]  DEV_ID     = 7'h50,
  parameter logic [7:0]  SPI_RD_OP  = 8'h03,
  parameter int          WAIT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_mode,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_data,
  output logic              cmd_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_ack,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic              boot_done,
  output logic              boot_busy,
  output logic              boot_error
);
  logic              xfer_go, xfer_done, xfer_nack, tmr_load, tmr_expired;
  logic [EE_AW-1:0]  xfer_addr;
  logic [CNT_W-1:0]  xfer_n;
  logic [BUF_W-1:0]  xfer_rx;
  logic              boot_we;
  logic [REG_AW-1:0] boot_addr;
  logic [7:0]        boot_wdata;

  boot_xfer #(.DEV_ID(DEV_ID), .SPI_RD_OP(SPI_RD_OP)) u_xfer (
    .clk, .rst_n, .spi_mode,
    .go(xfer_go), .start_addr(xfer_addr), .nbytes(xfer_n),
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_data, .cmd_last,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_ack,
    .done(xfer_done), .nack(xfer_nack), .rx_buf(xfer_rx)
  );

  boot_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk, .rst_n, .load(tmr_load), .len(wait_cycles), .expired(tmr_expired)
  );

  boot_ctrl #(.BOOT_MAGIC(BOOT_MAGIC)) u_ctrl (
    .clk, .rst_n,
    .xfer_go, .xfer_addr, .xfer_n, .xfer_done, .xfer_nack, .xfer_rx,
    .tmr_load, .tmr_expired,
    .boot_we, .boot_addr, .boot_wdata, .reg_rdata,
    .done(boot_done), .error(boot_error)
  );

  assign boot_busy = !boot_done;

  // register port belongs to the loader until done
  assign reg_we    = boot_busy ? boot_we    : host_we;
  assign reg_addr  = boot_busy ? boot_addr  : host_addr;
  assign reg_wdata = boot_busy ? boot_wdata : host_wdata;
endmodule

// File: rtl/eeprom_boot_chk.sv
module eeprom_boot_chk #(
  parameter int WAIT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_mode,
  input logic [WAIT_W-1:0] wait_cycles,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_data,
  input logic              cmd_last,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_ack,
  input logic              host_we,
  input logic              reg_we,
  input logic              boot_done,
  input logic              boot_busy,
  input logic              boot_error
);
  logic [1:0]  last_op;
  logic [31:0] gap_cnt;
  logic        gap_armed, nack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op   <= 2'd0;
      gap_cnt   <= '0;
      gap_armed <= 1'b0;
      nack_seen <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) last_op <= cmd_op;
      if (rsp_valid && rsp_ready && last_op == 2'd3) begin
        gap_cnt   <= '0;
        gap_armed <= 1'b1;
      end else if (gap_cnt != 32'hFFFF_FFFF) begin
        gap_cnt <= gap_cnt + 1;
      end
      if (rsp_valid && rsp_ready && last_op == 2'd1 && !spi_mode && !rsp_ack)
        nack_seen <= 1'b1;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data) && $stable(cmd_last)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && $stable(boot_error)); // R1
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !cmd_valid); // R1
  AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap_armed && cmd_valid && cmd_op == 2'd0 |-> gap_cnt >= 32'(wait_cycles)); // R5
  AST_NACK_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && nack_seen |-> boot_error); // R8
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy && reg_we |=> !reg_we); // R2
  AST_HOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && !host_we |-> !reg_we); // R10
endmodule

bind eeprom_boot eeprom_boot_chk #(.WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/eeprom_boot_tb.sv
module eeprom_boot_tb;
  localparam logic [15:0] MAGIC = 16'hB007;
  localparam logic [7:0]  DEVW  = 8'hA0;
  localparam logic [7:0]  DEVR  = 8'hA1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_mode = 1'b0;
  logic [15:0] wait_cycles = '0;
  logic        cmd_valid, cmd_ready, cmd_last, rsp_valid, rsp_ready, rsp_ack;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_data, rsp_data;
  logic        host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        boot_done, boot_busy, boot_error;

  eeprom_boot u_dut (
    .clk, .rst_n, .spi_mode, .wait_cycles,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_data, .cmd_last,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_ack,
    .host_we, .host_addr, .host_wdata,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .boot_done, .boot_busy, .boot_error
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] ee [0:255];
  logic [7:0] regs [0:255];
  assign reg_rdata = regs[reg_addr[7:0]];

  // scenario knobs and observations
  int   stall = 0, rdly = 0, n_bw = 0, n_stop = 0, lg_n = 0, min_gap = 0, t_stop = 0;
  bit   nack_dev = 0, ack_zero = 0, corrupt_en = 0, order_bad = 0, have_stop = 0;
  logic [7:0] corrupt_addr = '0;
  logic [1:0] lg_op [0:15];
  logic [7:0] lg_dat [0:15];
  logic       lg_last [0:15];

  function automatic logic [15:0] e_addr(input int i);
    return 16'(16'h0010 + i * 5);
  endfunction
  function automatic logic [7:0] e_data(input int i);
    return 8'hA0 ^ 8'(i * 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // register file: records writes, optionally corrupts one address
  initial forever begin
    logic [7:0] wv;
    @(negedge clk);
    if (rst_n && reg_we) begin
      wv = reg_wdata;
      if (corrupt_en && reg_addr[7:0] == corrupt_addr) wv = wv ^ 8'h01;
      regs[reg_addr[7:0]] = wv;
      if (boot_busy) begin
        if (reg_addr != e_addr(n_bw) || reg_wdata != e_data(n_bw)) order_bad = 1;
        n_bw++;
      end
    end
  end

  // serial engine and EEPROM model
  initial begin
    logic [1:0]  op_c;
    logic [7:0]  d_c, rd;
    logic        l_c, ack;
    logic [15:0] ptr;
    int          widx;
    ptr = '0; widx = 0;
    cmd_ready = 0; rsp_valid = 0; rsp_data = '0; rsp_ack = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid && rst_n) begin
        repeat (stall) @(negedge clk);
        op_c = cmd_op; d_c = cmd_data; l_c = cmd_last;
        if (op_c == 2'd0 && have_stop) begin
          if (cyc - t_stop < min_gap) min_gap = cyc - t_stop;
          have_stop = 0;
        end
        if (lg_n < 16) begin
          lg_op[lg_n] = op_c; lg_dat[lg_n] = d_c; lg_last[lg_n] = l_c;
        end
        lg_n++;
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        ack = 1; rd = '0;
        case (op_c)
          2'd0: widx = 0;
          2'd1: begin
            if (!(!spi_mode && d_c == DEVR)) begin
              if (widx == 1) ptr[15:8] = d_c;
              if (widx == 2) ptr[7:0]  = d_c;
              widx++;
            end
            ack = !((nack_dev && !spi_mode && d_c == DEVW) || ack_zero);
          end
          2'd2: begin rd = ee[ptr[7:0]]; ptr++; end
          default: n_stop++;
        endcase
        repeat (rdly) @(negedge clk);
        rsp_valid = 1; rsp_data = rd; rsp_ack = ack;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 0;
        if (op_c == 2'd3) begin t_stop = cyc; have_stop = 1; end
      end
    end
  end

  task automatic build_image(input logic [15:0] magic, input logic [15:0] count, input int n);
    for (int i = 0; i < 256; i++) ee[i] = 8'h00;
    ee[0] = magic[15:8]; ee[1] = magic[7:0];
    ee[2] = count[15:8]; ee[3] = count[7:0];
    for (int i = 0; i < n; i++) begin
      ee[4 + 3 * i] = e_addr(i)[15:8];
      ee[5 + 3 * i] = e_addr(i)[7:0];
      ee[6 + 3 * i] = e_data(i);
    end
  endtask

  task automatic start_boot(input logic spi, input logic [15:0] w);
    rst_n = 0;
    spi_mode = spi; wait_cycles = w;
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    n_bw = 0; n_stop = 0; lg_n = 0; min_gap = 1 << 30; have_stop = 0; order_bad = 0;
    repeat (3) @(negedge clk);
    chk(boot_busy == 1 && boot_done == 0 && boot_error == 0 && cmd_valid == 0, "R1",
        "reset busy/done/error/cmd", {boot_busy, boot_done, boot_error, cmd_valid}, 4'b1000);
    rst_n = 1;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!boot_done && t < 20000) begin @(negedge clk); t++; end
    chk(boot_done, "R1", "boot completes", boot_done, 1);
    chk(!boot_busy, "R1", "busy falls at done", boot_busy, 0);
  endtask

  task automatic check_regs(input string req, input int n);
    for (int i = 0; i < n; i++)
      chk(regs[e_addr(i)[7:0]] == e_data(i), req, "register content",
          regs[e_addr(i)[7:0]], e_data(i));
    chk(n_bw == n && !order_bad, req, "boot write count/order", n_bw, n);
  endtask

  task automatic t_i2c_good();
    stall = 1; rdly = 2; nack_dev = 0; ack_zero = 0; corrupt_en = 0;
    build_image(MAGIC, 16'd6, 6);
    start_boot(1'b0, 16'd5);
    repeat (20) @(negedge clk);
    #1 host_we = 1; host_addr = 16'h00F0; host_wdata = 8'h5A;
    @(negedge clk);
    #1 host_we = 0;
    wait_done();
    chk(!boot_error, "R9", "clean verify leaves error low", boot_error, 0);
    check_regs("R2", 6);
    chk(regs[8'hF0] == 8'h00, "R10", "host write blocked while busy", regs[8'hF0], 0);
    chk(min_gap >= 5, "R5", "gap between transfers", min_gap, 5);
    chk(lg_op[0] == 0 && lg_op[1] == 1 && lg_dat[1] == DEVW && lg_op[2] == 1 && lg_dat[2] == 0 &&
        lg_op[3] == 1 && lg_dat[3] == 0 && lg_op[4] == 0 && lg_op[5] == 1 && lg_dat[5] == DEVR,
        "R6", "I2C address phase", {lg_op[1], lg_dat[1]}, {2'd1, DEVW});
    chk(lg_op[6] == 2 && lg_op[9] == 2 && lg_op[10] == 3 && !lg_last[8] && lg_last[9],
        "R6", "I2C read/stop and last flag", {lg_op[10], lg_last[9]}, {2'd3, 1'b1});
    chk(n_stop == 13, "R9", "stops for header, load and verify", n_stop, 13);
    @(negedge clk);
    #1 host_we = 1; host_addr = 16'h00F0; host_wdata = 8'h5A;
    @(negedge clk);
    #1 host_we = 0;
    @(negedge clk);
    chk(regs[8'hF0] == 8'h5A, "R10", "host write after done", regs[8'hF0], 8'h5A);
  endtask

  task automatic t_spi_good();
    stall = 3; rdly = 0; nack_dev = 0; ack_zero = 1; corrupt_en = 0;
    build_image(MAGIC, 16'd4, 4);
    start_boot(1'b1, 16'd0);
    wait_done();
    chk(!boot_error, "R7", "SPI ignores zero ack", boot_error, 0);
    check_regs("R7", 4);
    chk(lg_op[0] == 0 && lg_op[1] == 1 && lg_dat[1] == 8'h03 && lg_dat[2] == 0 && lg_dat[3] == 0 &&
        lg_op[4] == 2 && lg_op[7] == 2 && lg_last[7] && !lg_last[6] && lg_op[8] == 3,
        "R7", "SPI framing", {lg_op[1], lg_dat[1]}, {2'd1, 8'h03});
  endtask

  task automatic t_bad_magic();
    stall = 0; rdly = 1; nack_dev = 0; ack_zero = 0; corrupt_en = 0;
    build_image(16'hB006, 16'd3, 3);
    start_boot(1'b0, 16'd3);
    wait_done();
    chk(boot_error, "R3", "wrong magic sets error", boot_error, 1);
    chk(n_bw == 0, "R3", "no writes on wrong magic", n_bw, 0);
  endtask

  task automatic t_zero_count();
    stall = 0; rdly = 0; nack_dev = 0; ack_zero = 0; corrupt_en = 0;
    build_image(MAGIC, 16'd0, 0);
    start_boot(1'b1, 16'd3);
    wait_done();
    chk(!boot_error && n_bw == 0, "R4", "empty image", {boot_error, 8'(n_bw)}, 0);
    chk(n_stop == 1, "R4", "only the header transfer", n_stop, 1);
  endtask

  task automatic t_oversize();
    stall = 0; rdly = 0; nack_dev = 0; ack_zero = 0; corrupt_en = 0;
    build_image(MAGIC, 16'h6000, 6);
    start_boot(1'b0, 16'd3);
    wait_done();
    chk(boot_error && n_bw == 0, "R4", "oversize count", {boot_error, 8'(n_bw)}, 9'h100);
  endtask

  task automatic t_nack();
    stall = 0; rdly = 1; nack_dev = 1; ack_zero = 0; corrupt_en = 0;
    build_image(MAGIC, 16'd3, 3);
    start_boot(1'b0, 16'd3);
    wait_done();
    chk(boot_error, "R8", "nack sets error", boot_error, 1);
    chk(n_bw == 0, "R8", "no write after nack", n_bw, 0);
    chk(n_stop == 1 && lg_n == 3, "R8", "stop follows nacked byte", lg_n, 3);
  endtask

  task automatic t_verify_bad();
    stall = 1; rdly = 1; nack_dev = 0; ack_zero = 0; corrupt_en = 1;
    corrupt_addr = e_addr(2)[7:0];
    build_image(MAGIC, 16'd4, 4);
    start_boot(1'b1, 16'd2);
    wait_done();
    chk(boot_error, "R9", "verify mismatch sets error", boot_error, 1);
    chk(n_bw == 4, "R9", "all entries loaded before verify", n_bw, 4);
    chk(n_stop == 8, "R9", "verify stops at bad entry", n_stop, 8);
  endtask

  initial begin
    t_i2c_good();
    t_spi_good();
    t_bad_magic();
    t_zero_count();
    t_oversize();
    t_nack();
    t_verify_bad();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule